// File: doc/BRIEF.md
# Bimodal Direction and Target Predictor

This block sits beside the fetch stage and, for each branch address presented to it, gives a taken/not-taken guess and the address that fetch should continue from. The dynamic modes read a table of 2048 small saturating counters, selected by the branch address bits just above the word offset. A 512-entry, 4-way set-associative branch target buffer is searched in the same cycle. A 3-bit mode input picks one of five policies: one-bit last-outcome counters, two-bit hysteresis counters, always taken, never taken, or backward-taken/forward-not-taken.

The direction and the target are looked up separately. A counter can therefore call a branch taken while the target buffer holds no entry for it. In that case the block reports the branch as taken but marks the next address as unknown, and it offers the sequential address in its place. Resolved branches return on an update port. That port trains the counters and writes the targets of taken branches into the target buffer. Lookups are registered, so results appear one cycle after the request. An update in the same cycle as a lookup takes effect before the lookup reads.

Addresses are byte addresses of word-aligned instructions, so the sequential address is always the branch address plus 4.

Top module: `bp_predictor`

## Requirements
- R1: A result appears one cycle after a lookup. `predValid` is high in the cycle after `lookupValid` was high and low otherwise. While reset is held, `predValid`, `predTaken`, `predKnown` and `predNext` are all zero.
- R2: The counter table has 2048 two-bit entries, selected by address bits [12:2]. Every entry resets to 1 (weakly not taken), so a branch never seen before is predicted not taken.
- R3: Two-bit mode (mode 1) predicts taken when the entry is 2 or 3. A taken update adds one to the entry and stops at 3. A not-taken update subtracts one and stops at 0.
- R4: One-bit mode (mode 0) predicts the outcome last written to the entry. Each update overwrites the entry with the resolved outcome, so one wrong guess flips the next prediction.
- R5: In both counter modes, the output depends on the direction and on the target buffer. Taken with a hit gives the stored target with `predKnown`=1. Taken with a miss gives `predKnown`=0 and the branch address plus 4. Not taken gives the branch address plus 4 with `predKnown`=1.
- R6: The target buffer holds 512 entries in 128 sets of 4 ways. The set is taken from address bits [8:2] and the tag from bits [31:9]. Only updates with the taken flag set write it: such an update refreshes an existing entry or installs a new one.
- R7: A new entry goes into the lowest-numbered invalid way of its set. If no way is invalid, it replaces the way written least recently. Installing an entry and refreshing one both count as a write.
- R8: Always-taken mode (mode 2) predicts taken, with `predKnown`=1 and `predNext` equal to `lookupTarget`.
- R9: Never-taken mode (mode 3) predicts not taken, with `predKnown`=1 and `predNext` equal to the branch address plus 4. Mode codes 5 to 7 behave the same way.
- R10: Backward mode (mode 4) predicts taken with next address `lookupTarget` when the branch address is greater than `lookupTarget`, compared unsigned. Otherwise, including when the two are equal, it predicts not taken with the branch address plus 4.
- R11: When an update and a lookup fall in the same cycle, the lookup sees the state after the update. This holds both for the counter entry they share and for the target buffer entry of the updated address.
- R12: Counters train only in modes 0 and 1. An update in a static mode leaves every counter unchanged, but a taken update still writes the target buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Policy select: 0 one-bit, 1 two-bit, 2 always taken, 3 never taken, 4 backward taken |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupPc | input | 32 | Address of the branch being looked up |
| lookupTarget | input | 32 | Decoded target of that branch, used by the static policies |
| updValid | input | 1 | Resolved branch present this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| updTarget | input | 32 | Resolved target address |
| predValid | output | 1 | Registered result valid |
| predTaken | output | 1 | Predicted direction |
| predKnown | output | 1 | 1 when `predNext` is a real prediction, 0 for taken with target unknown |
| predNext | output | 32 | Predicted next fetch address |

## Verification
The assertions check several properties on every cycle:
- the one-cycle result timing;
- that a not-taken result always carries a known next address;
- the fixed outcomes of the always-taken, never-taken and equal-address backward cases;
- that no target set ever holds two matching ways;
- that each set always has exactly one oldest way;
- that two-bit counters hold at their limits.

Other behaviours show up only over sequences, so only the bench scenarios can show them:
- counter training sequences, including the one-bit flip after a single miss compared with two-bit hysteresis;
- the taken-with-unknown-target case, built by aliasing the counter index while the tag differs;
- the same-cycle update-before-lookup ordering;
- eviction of the least recently written way after a refresh;
- static-mode updates leaving the counters untouched while still filling the target buffer.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    MODE_ONE_BIT      = 3'd0,
    MODE_TWO_BIT      = 3'd1,
    MODE_ALWAYS_TAKEN = 3'd2,
    MODE_NEVER_TAKEN  = 3'd3,
    MODE_BACKWARD     = 3'd4
  } bp_mode_e;

  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic trainCnt;      // counters may be written by updates
    logic oneBit;        // counter cells store last outcome only
    logic useCounter;    // direction comes from the counter table
    logic forceTaken;    // static taken policy
    logic forceNotTaken; // static not-taken policy
    logic useBackward;   // static backward-taken policy
  } bp_strobe_t;

endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic [2:0] mode,
  output bp_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    case (mode)
      MODE_ONE_BIT: begin
        strobe.useCounter = 1'b1;
        strobe.trainCnt   = 1'b1;
        strobe.oneBit     = 1'b1;
      end
      MODE_TWO_BIT: begin
        strobe.useCounter = 1'b1;
        strobe.trainCnt   = 1'b1;
      end
      MODE_ALWAYS_TAKEN: strobe.forceTaken  = 1'b1;
      MODE_BACKWARD:     strobe.useBackward = 1'b1;
      default:           strobe.forceNotTaken = 1'b1;  // R9: codes 3, 5..7
    endcase
  end

endmodule

// File: rtl/bp_cnt_table.sv
module bp_cnt_table #(
  parameter int ENTRIES = 2048,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrTaken,
  input  logic             oneBit,
  output logic [1:0]       rdCnt
);

  logic [1:0] cntMem [ENTRIES];
  logic [1:0] curW;
  logic [1:0] nextW;

  always_comb begin
    curW = cntMem[wrIdx];
    if (oneBit) begin
      nextW = wrTaken ? 2'b11 : 2'b00;               // R4
    end else if (wrTaken) begin
      nextW = (curW == 2'b11) ? curW : curW + 2'd1;  // R3
    end else begin
      nextW = (curW == 2'b00) ? curW : curW - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) cntMem[i] <= 2'b01;  // R2
    end else if (wrEn) begin
      cntMem[wrIdx] <= nextW;
    end
  end

  // R11: a same-cycle write to the read entry is seen by the read
  assign rdCnt = (wrEn && (wrIdx == rdIdx)) ? nextW : cntMem[rdIdx];

  a_r3_hold_top: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !oneBit && wrTaken && curW == 2'b11) |=> cntMem[$past(wrIdx)] == 2'b11);

  a_r3_hold_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !oneBit && !wrTaken && curW == 2'b00) |=> cntMem[$past(wrIdx)] == 2'b00);

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 512,
  parameter int WAYS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdPc,
  output logic              rdHit,
  output logic [ADDR_W-1:0] rdTarget,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrPc,
  input  logic [ADDR_W-1:0] wrTarget
);

  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - 2 - SET_W;

  logic              vldMem [SETS][WAYS];
  logic [TAG_W-1:0]  tagMem [SETS][WAYS];
  logic [ADDR_W-1:0] tgtMem [SETS][WAYS];
  logic [WAY_W-1:0]  ageMem [SETS][WAYS];

  logic [SET_W-1:0] wrSet, rdSet;
  logic [TAG_W-1:0] wrTag, rdTag;
  assign wrSet = wrPc[2 +: SET_W];
  assign rdSet = rdPc[2 +: SET_W];
  assign wrTag = wrPc[ADDR_W-1 -: TAG_W];
  assign rdTag = rdPc[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] wrMatch, rdMatch, rdLive, oldestVec;
  logic [WAY_W-1:0] hitWay, freeWay, oldWay, wrWay, wrOldAge;
  logic wrHit, anyFree, fwdHit;
  logic [ADDR_W-1:0] liveTgt;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      wrMatch[w]   = vldMem[wrSet][w] && (tagMem[wrSet][w] == wrTag);
      rdMatch[w]   = vldMem[rdSet][w] && (tagMem[rdSet][w] == rdTag);
      oldestVec[w] = (ageMem[wrSet][w] == WAY_W'(WAYS - 1));
    end
  end

  // R6/R7: refresh a matching way, else the lowest free way, else the oldest
  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    oldWay  = '0;
    wrHit   = 1'b0;
    anyFree = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wrMatch[w]) begin
        hitWay = WAY_W'(w);
        wrHit  = 1'b1;
      end
      if (!vldMem[wrSet][w]) begin
        freeWay = WAY_W'(w);
        anyFree = 1'b1;
      end
      if (oldestVec[w]) oldWay = WAY_W'(w);
    end
    wrWay    = wrHit ? hitWay : (anyFree ? freeWay : oldWay);
    wrOldAge = ageMem[wrSet][wrWay];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vldMem[s][w] <= 1'b0;
          tagMem[s][w] <= '0;
          tgtMem[s][w] <= '0;
          ageMem[s][w] <= WAY_W'(w);
        end
      end
    end else if (wrEn) begin
      vldMem[wrSet][wrWay] <= 1'b1;
      tagMem[wrSet][wrWay] <= wrTag;
      tgtMem[wrSet][wrWay] <= wrTarget;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == wrWay) begin
          ageMem[wrSet][w] <= '0;
        end else if (ageMem[wrSet][w] < wrOldAge) begin
          ageMem[wrSet][w] <= ageMem[wrSet][w] + WAY_W'(1);
        end
      end
    end
  end

  // R11: read sees the table as it stands after a same-cycle write
  assign fwdHit = wrEn && (wrPc == rdPc);

  always_comb begin
    liveTgt = '0;
    for (int w = 0; w < WAYS; w++) begin
      rdLive[w] = rdMatch[w] && !(wrEn && (wrSet == rdSet) && (wrWay == WAY_W'(w)));
      if (rdLive[w]) liveTgt = tgtMem[rdSet][w];
    end
    rdHit    = fwdHit || (|rdLive);
    rdTarget = fwdHit ? wrTarget : liveTgt;
  end

  a_r6_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdMatch));

  a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oldestVec) == 1);

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_ENTRIES = 2048,
  parameter int BTB_ENTRIES = 512,
  parameter int BTB_WAYS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bp_strobe_t        strobe,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ADDR_W-1:0] lookupTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              predValid,
  output logic              predTaken,
  output logic              predKnown,
  output logic [ADDR_W-1:0] predNext
);

  localparam int IDX_W = $clog2(CNT_ENTRIES);

  logic [1:0]        cntVal;
  logic              btbHit;
  logic [ADDR_W-1:0] btbTarget;
  logic [ADDR_W-1:0] seqNext;
  logic              backTaken;
  logic              nxtTaken, nxtKnown;
  logic [ADDR_W-1:0] nxtAddr;

  bp_cnt_table #(.ENTRIES(CNT_ENTRIES)) cntTable_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdx   (lookupPc[2 +: IDX_W]),
    .wrEn    (updValid && strobe.trainCnt),  // R12
    .wrIdx   (updPc[2 +: IDX_W]),
    .wrTaken (updTaken),
    .oneBit  (strobe.oneBit),
    .rdCnt   (cntVal)
  );

  bp_btb #(.ADDR_W(ADDR_W), .ENTRIES(BTB_ENTRIES), .WAYS(BTB_WAYS)) btb_i (
    .clk      (clk),
    .rstN     (rstN),
    .rdPc     (lookupPc),
    .rdHit    (btbHit),
    .rdTarget (btbTarget),
    .wrEn     (updValid && updTaken),  // R6
    .wrPc     (updPc),
    .wrTarget (updTarget)
  );

  assign seqNext   = lookupPc + ADDR_W'(4);
  assign backTaken = lookupPc > lookupTarget;  // R10

  always_comb begin
    nxtTaken = 1'b0;
    nxtKnown = 1'b1;
    nxtAddr  = seqNext;
    if (strobe.forceTaken) begin
      nxtTaken = 1'b1;
      nxtAddr  = lookupTarget;
    end else if (strobe.useBackward) begin
      nxtTaken = backTaken;
      nxtAddr  = backTaken ? lookupTarget : seqNext;
    end else if (strobe.useCounter) begin
      nxtTaken = cntVal[1];  // R3/R4: upper bit is the direction
      if (cntVal[1] && btbHit) nxtAddr = btbTarget;
      else if (cntVal[1]) nxtKnown = 1'b0;  // R5: target unknown
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predTaken <= 1'b0;
      predKnown <= 1'b0;
      predNext  <= '0;
    end else begin
      predValid <= lookupValid;
      if (lookupValid) begin
        predTaken <= nxtTaken;
        predKnown <= nxtKnown;
        predNext  <= nxtAddr;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    predValid == $past(lookupValid));

  a_r5_not_taken_known: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !predTaken) |-> predKnown);

  a_r8_always_taken: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && strobe.forceTaken) |=>
      (predTaken && predKnown && predNext == $past(lookupTarget)));

  a_r9_never_taken: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && strobe.forceNotTaken) |=>
      (!predTaken && predNext == $past(lookupPc) + ADDR_W'(4)));

  a_r10_equal_forward: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && strobe.useBackward && lookupPc == lookupTarget) |=> !predTaken);

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_ENTRIES = 2048,
  parameter int BTB_ENTRIES = 512,
  parameter int BTB_WAYS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ADDR_W-1:0] lookupTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              predValid,
  output logic              predTaken,
  output logic              predKnown,
  output logic [ADDR_W-1:0] predNext
);

  bp_strobe_t strobe;

  bp_ctrl ctrl_i (
    .mode   (mode),
    .strobe (strobe)
  );

  bp_datapath #(
    .ADDR_W      (ADDR_W),
    .CNT_ENTRIES (CNT_ENTRIES),
    .BTB_ENTRIES (BTB_ENTRIES),
    .BTB_WAYS    (BTB_WAYS)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lookupValid  (lookupValid),
    .lookupPc     (lookupPc),
    .lookupTarget (lookupTarget),
    .updValid     (updValid),
    .updPc        (updPc),
    .updTaken     (updTaken),
    .updTarget    (updTarget),
    .predValid    (predValid),
    .predTaken    (predTaken),
    .predKnown    (predKnown),
    .predNext     (predNext)
  );

endmodule

// File: tb/bp_predictor_tb.sv
module bp_predictor_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mode = 3'd1;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupPc = '0;
  logic [31:0] lookupTarget = '0;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  logic        predValid, predTaken, predKnown;
  logic [31:0] predNext;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bp_predictor dut_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupTarget(lookupTarget),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .predValid(predValid), .predTaken(predTaken), .predKnown(predKnown),
    .predNext(predNext)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utgt;
    logic        lv;
    logic [31:0] lpc;
    logic [31:0] ltgt;
    logic        eT;
    logic        eK;
    logic [31:0] eNext;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    // R2: fresh entry is weakly not taken
    '{3'd1, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd2},
    // R11: same-cycle update seen by the lookup (counter 2, target forwarded)
    '{3'd1, 1'b1, 32'h100,  1'b1, 32'h80,   1'b1, 32'h100, 32'h80,  1'b1, 1'b1, 32'h80,  8'd11},
    // R3: down to 1, 0, held at 0
    '{3'd1, 1'b1, 32'h100,  1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd3},
    '{3'd1, 1'b1, 32'h100,  1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd3},
    '{3'd1, 1'b1, 32'h100,  1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd3},
    // R3: 0 -> 1 still not taken (no wrap at 0)
    '{3'd1, 1'b1, 32'h100,  1'b1, 32'h80,   1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd3},
    // R5: 2 -> taken with stored target
    '{3'd1, 1'b1, 32'h100,  1'b1, 32'h80,   1'b1, 32'h100, 32'h80,  1'b1, 1'b1, 32'h80,  8'd5},
    '{3'd1, 1'b1, 32'h100,  1'b1, 32'h80,   1'b0, 32'h0,   32'h0,   1'b0, 1'b0, 32'h0,   8'd3},
    '{3'd1, 1'b1, 32'h100,  1'b1, 32'h80,   1'b0, 32'h0,   32'h0,   1'b0, 1'b0, 32'h0,   8'd3},
    // R3: held at 3, one not-taken leaves 2, still taken
    '{3'd1, 1'b1, 32'h100,  1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b1, 1'b1, 32'h80,  8'd3},
    // R5: alias counter via 0x2200, lookup 0x200 misses in the target buffer
    '{3'd1, 1'b1, 32'h2200, 1'b1, 32'h3000, 1'b0, 32'h0,   32'h0,   1'b0, 1'b0, 32'h0,   8'd5},
    '{3'd1, 1'b1, 32'h2200, 1'b1, 32'h3000, 1'b1, 32'h200, 32'h0,   1'b1, 1'b0, 32'h204, 8'd5},
    // R4: one-bit reads upper bit (taken, unknown target)
    '{3'd0, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h200, 32'h0,   1'b1, 1'b0, 32'h204, 8'd4},
    // R4: one miss flips the prediction
    '{3'd0, 1'b1, 32'h200,  1'b0, 32'h0,    1'b1, 32'h200, 32'h0,   1'b0, 1'b1, 32'h204, 8'd4},
    '{3'd0, 1'b1, 32'h200,  1'b1, 32'h500,  1'b1, 32'h200, 32'h0,   1'b1, 1'b1, 32'h500, 8'd4},
    '{3'd0, 1'b1, 32'h200,  1'b0, 32'h0,    1'b1, 32'h200, 32'h0,   1'b0, 1'b1, 32'h204, 8'd4},
    // R8
    '{3'd2, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h100, 32'h900, 1'b1, 1'b1, 32'h900, 8'd8},
    // R9: trained entry ignored
    '{3'd3, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd9},
    // R10: backward, forward, equal
    '{3'd4, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h400, 32'h300, 1'b1, 1'b1, 32'h300, 8'd10},
    '{3'd4, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h400, 32'h500, 1'b0, 1'b1, 32'h404, 8'd10},
    '{3'd4, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h400, 32'h400, 1'b0, 1'b1, 32'h404, 8'd10},
    // R12: not-taken update in static mode, then counter still at 2
    '{3'd3, 1'b1, 32'h100,  1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b0, 1'b1, 32'h104, 8'd12},
    '{3'd1, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 32'h100, 32'h80,  1'b1, 1'b1, 32'h80,  8'd12},
    // R12: static-mode taken update still installs a target
    '{3'd2, 1'b1, 32'h600,  1'b1, 32'h700,  1'b0, 32'h0,   32'h0,   1'b0, 1'b0, 32'h0,   8'd12},
    '{3'd1, 1'b1, 32'h2600, 1'b1, 32'h1111, 1'b1, 32'h600, 32'h0,   1'b1, 1'b1, 32'h700, 8'd12}
  };

  task automatic runCycle(input logic [2:0] m, input logic uv, input logic [31:0] upc,
                          input logic ut, input logic [31:0] utgt, input logic lv,
                          input logic [31:0] lpc, input logic [31:0] ltgt);
    @(negedge clk);
    mode = m; updValid = uv; updPc = upc; updTaken = ut; updTarget = utgt;
    lookupValid = lv; lookupPc = lpc; lookupTarget = ltgt;
    @(posedge clk);
    #5;
  endtask

  task automatic expectOut(input int req, input logic eT, input logic eK,
                           input logic [31:0] eNext);
    checks++;
    if (predValid !== 1'b1 || predTaken !== eT || predKnown !== eK || predNext !== eNext) begin
      errors++;
      $display("FAIL R%0d: got valid=%0b taken=%0b known=%0b next=%h, expected valid=1 taken=%0b known=%0b next=%h",
               req, predValid, predTaken, predKnown, predNext, eT, eK, eNext);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: outputs cleared while reset is held
    checks++;
    if (predValid !== 1'b0 || predTaken !== 1'b0 || predKnown !== 1'b0 || predNext !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs valid=%0b taken=%0b known=%0b next=%h, expected all zero",
               predValid, predTaken, predKnown, predNext);
    end
    @(negedge clk);
    rstN = 1'b1;
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
    checks++;
    if (predValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: predValid=%0b without lookup, expected 0", predValid);
    end

    for (int i = 0; i < NVEC; i++) begin
      runCycle(VECS[i].mode, VECS[i].uv, VECS[i].upc, VECS[i].ut, VECS[i].utgt,
               VECS[i].lv, VECS[i].lpc, VECS[i].ltgt);
      if (VECS[i].lv) expectOut(int'(VECS[i].req), VECS[i].eT, VECS[i].eK, VECS[i].eNext);
    end

    // R1: valid drops the cycle after a lookup-free cycle
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
    checks++;
    if (predValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: predValid=%0b after idle cycle, expected 0", predValid);
    end

    // R7: fill set 5 with A..D, refresh A, install E, B must be the victim
    runCycle(3'd1, 1'b1, 32'h1014, 1'b1, 32'hA000, 1'b0, 32'h0, 32'h0);
    runCycle(3'd1, 1'b1, 32'h1214, 1'b1, 32'hB000, 1'b0, 32'h0, 32'h0);
    runCycle(3'd1, 1'b1, 32'h1414, 1'b1, 32'hC000, 1'b0, 32'h0, 32'h0);
    runCycle(3'd1, 1'b1, 32'h1614, 1'b1, 32'hD000, 1'b0, 32'h0, 32'h0);
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1014, 32'h0);
    expectOut(6, 1'b1, 1'b1, 32'hA000);  // R6: four ways of one set coexist
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1614, 32'h0);
    expectOut(6, 1'b1, 1'b1, 32'hD000);  // R6
    runCycle(3'd1, 1'b1, 32'h1014, 1'b1, 32'hA000, 1'b0, 32'h0, 32'h0);
    runCycle(3'd1, 1'b1, 32'h1814, 1'b1, 32'hE000, 1'b0, 32'h0, 32'h0);
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1214, 32'h0);
    expectOut(7, 1'b1, 1'b0, 32'h1218);  // R7: B evicted
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1014, 32'h0);
    expectOut(7, 1'b1, 1'b1, 32'hA000);  // R7: refreshed A kept
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1414, 32'h0);
    expectOut(7, 1'b1, 1'b1, 32'hC000);  // R7
    runCycle(3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h1814, 32'h0);
    expectOut(7, 1'b1, 1'b1, 32'hE000);  // R7

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule